// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache Controller

This block is a direct-mapped cache controller for one of two processors that share a single bus and a common memory. Every line holds one data word, a tag and a coherence bit. The bit has two values: Valid, where the line matches memory, and Invalid. Read hits are served from the line in the same cycle, with no bus traffic. Read misses fetch the word from memory. Every processor write goes through to memory as a write-invalidate bus transaction, whether it hits or misses. Memory therefore always holds the newest value, and a victim line is dropped without a write-back.

The controller also watches write-invalidate transactions issued by the other cache. When such a transaction names an address held in a Valid line, that line becomes Invalid at the next clock edge. While a bus transaction is open, the processor is held off with ready low. Only one transaction is open at a time. The bus grant is fixed. Memory answers each request with a one-cycle done pulse, and on a read that pulse carries the data.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset every line is Invalid, so the first read of any address is a miss that starts a bus read.
- R2: A read whose index holds a Valid line with a matching tag raises cpuReady in the same cycle as the request. It returns the stored word and starts no bus transaction.
- R3: A read miss raises busReq with busWrite=0 in the cycle after the request. cpuReady rises in the cycle busDone is high, returning busRdata. The line is then Valid with that word, so the next read of the address is a hit.
- R4: A line whose tag matches but whose state is Invalid is treated as a miss.
- R5: A write hit issues one bus transaction with busWrite=1 that carries the address and data to memory. The local copy is updated, so a later read hits and returns the written word.
- R6: A write miss issues one write bus transaction, the same as a write hit. The target line is left Valid with the written word and the new tag.
- R7: Replacing a Valid line, on a read miss or a write miss, issues exactly one bus transaction and no write-back. The replaced address misses afterwards and returns the memory value.
- R8: A snoop (snpValid high) whose address matches a Valid line makes that line Invalid from the next clock edge. A read issued in the following cycle misses and returns the current memory value.
- R9: A snoop whose tag differs from the stored tag, or that targets an Invalid line, leaves the cache contents unchanged.
- R10: While busReq is high and busDone is low, cpuReady is low. busReq, busWrite and busAddr stay steady until busDone, and a new transaction starts only after that.
- R11: The address index is the low INDEX_W bits of the address, and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuReady |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor word address |
| cpuWdata | input | DATA_W | Processor write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady |
| busReq | output | 1 | Bus transaction open |
| busWrite | output | 1 | 1 = write-invalidate, 0 = read |
| busAddr | output | ADDR_W | Bus transaction address |
| busWdata | output | DATA_W | Bus write data |
| busDone | input | 1 | Memory completion pulse |
| busRdata | input | DATA_W | Memory read data, valid with busDone |
| snpValid | input | 1 | Other cache's write-invalidate is on the bus |
| snpAddr | input | ADDR_W | Address of the snooped write |

## Verification
The tests apply reads to cold, warm and conflicting addresses. The number of bus transactions and the latency of each access separate a hit from a miss, and a replacement from a write-back. Writes are aimed both at lines already present and at empty or occupied indices of another tag, so the write-hit and write-miss paths can be told apart by the memory contents and by the later read hit. Snoops target a matching line, a line at the same index with a different tag, and an empty line. The bench changes memory behind the cache, so only a real invalidation can make the later read return the new value.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } wtc_state_t;

  typedef struct packed {
    logic fill;      // write the request's line this edge
    logic fromBus;   // fill data from memory (read) rather than processor (write)
    logic snoopInv;  // clear the snooped line
  } wtc_strobe_t;

endpackage

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wtc_strobe_t       strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              hit,
  output logic [DATA_W-1:0] lineData,
  output logic              snoopHit
);

  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [INDEX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0]   cpuTag, snpTag;
  logic [LINES-1:0]   validQ;
  logic [TAG_W-1:0]   tagQ  [LINES];
  logic [DATA_W-1:0]  dataQ [LINES];
  logic [DATA_W-1:0]  fillData;

  // R11: index from low bits, tag from the rest
  assign cpuIdx   = cpuAddr[INDEX_W-1:0];
  assign cpuTag   = cpuAddr[ADDR_W-1:INDEX_W];
  assign snpIdx   = snpAddr[INDEX_W-1:0];
  assign snpTag   = snpAddr[ADDR_W-1:INDEX_W];
  assign fillData = strb.fromBus ? busRdata : cpuWdata;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic lineFill, lineInv;
    assign lineFill = strb.fill && (cpuIdx == INDEX_W'(i));
    assign lineInv  = strb.snoopInv && (snpIdx == INDEX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
      end else if (lineFill) begin
        validQ[i] <= 1'b1;
      end else if (lineInv) begin
        validQ[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (lineFill) begin
        tagQ[i]  <= cpuTag;
        dataQ[i] <= fillData;
      end
    end
  end

  // R4: a stored tag on an Invalid line never counts
  assign hit      = validQ[cpuIdx] && (tagQ[cpuIdx] == cpuTag);
  assign lineData = dataQ[cpuIdx];
  assign snoopHit = snpValid && validQ[snpIdx] && (tagQ[snpIdx] == snpTag);

  a_r1_reset_invalid: assert property (@(posedge clk)
    !rstN |=> (validQ == '0));

  a_r3_fill_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |=> validQ[$past(cpuIdx)]);

  a_r8_snoop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (snoopHit && !(strb.fill && cpuIdx == snpIdx)) |=> !validQ[$past(snpIdx)]);

endmodule

// File: rtl/wtc_control.sv
module wtc_control
  import wtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWrite,
  input  logic        hit,
  input  logic        snoopHit,
  input  logic        busDone,
  output wtc_strobe_t strb,
  output logic        cpuReady,
  output logic        rdFromBus,
  output logic        busReq,
  output logic        busWrite
);

  wtc_state_t stateQ, stateD;
  logic       opWriteQ;
  logic       needBus;

  // reads that hit stay local; every write and every read miss goes to the bus
  assign needBus = cpuReq && (cpuWrite || !hit);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (needBus) stateD = ST_BUS;
      ST_BUS:  if (busDone) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      opWriteQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && needBus) opWriteQ <= cpuWrite;
    end
  end

  assign busReq    = (stateQ == ST_BUS);
  assign busWrite  = busReq && opWriteQ;
  assign rdFromBus = busReq;
  assign cpuReady  = (stateQ == ST_IDLE) ? (cpuReq && !cpuWrite && hit) : busDone;

  always_comb begin
    strb          = '0;
    strb.fill     = busReq && busDone;
    strb.fromBus  = !opWriteQ;
    strb.snoopInv = snoopHit;
  end

  a_r10_ready_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |-> !cpuReady);

  a_r10_bus_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> (busReq && $stable(busWrite)));

  a_r2_hit_local: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && cpuReq && !cpuWrite && hit) |-> (cpuReady && !busReq));

  a_r5_write_on_bus: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && cpuReq && cpuWrite) |=> (busReq && busWrite));

endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr
);

  wtc_strobe_t       strb;
  logic              hit, snoopHit, rdFromBus;
  logic [DATA_W-1:0] lineData;

  wtc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWrite (cpuWrite),
    .hit      (hit),
    .snoopHit (snoopHit),
    .busDone  (busDone),
    .strb     (strb),
    .cpuReady (cpuReady),
    .rdFromBus(rdFromBus),
    .busReq   (busReq),
    .busWrite (busWrite)
  );

  wtc_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .INDEX_W(INDEX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .busRdata (busRdata),
    .snpValid (snpValid),
    .snpAddr  (snpAddr),
    .hit      (hit),
    .lineData (lineData),
    .snoopHit (snoopHit)
  );

  // processor holds address and data until ready, so the bus reuses them
  assign busAddr  = cpuAddr;
  assign busWdata = cpuWdata;
  assign cpuRdata = rdFromBus ? busRdata : lineData;

endmodule

// File: tb/tb_snoop_wt_cache.sv
module tb_snoop_wt_cache;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuReady;
  logic [DW-1:0] cpuRdata;
  logic          busReq, busWrite;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic          busDone = 1'b0;
  logic [DW-1:0] busRdata = '0;
  logic          snpValid = 1'b0;
  logic [AW-1:0] snpAddr = '0;

  logic [DW-1:0] mem [256];
  logic          extWr = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [DW-1:0] extData = '0;
  int txCnt = 0, wrCnt = 0;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  snoop_wt_cache dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busDone(busDone),
    .busRdata(busRdata), .snpValid(snpValid), .snpAddr(snpAddr)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = DW'(16'h1000 + i * 3);

  // shared memory: answers one cycle after a request is seen
  always @(posedge clk) begin
    if (!rstN) begin
      busDone <= 1'b0;
    end else begin
      busDone <= busReq && !busDone;
      if (busReq && !busDone) begin
        busRdata <= mem[busAddr];
        if (busWrite) mem[busAddr] <= busWdata;
      end
      if (busDone) begin
        txCnt <= txCnt + 1;
        if (busWrite) wrCnt <= wrCnt + 1;
      end
      if (extWr) mem[extAddr] <= extData;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10 monitor: ready must stay low while a transaction is open
  always @(negedge clk) begin
    if (rstN && busReq && !busDone && cpuReady) begin
      failures++;
      $display("FAIL R10 actual=ready_high expected=ready_low");
    end
  end

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd;
    #1;
    lat = 0;
    while (!cpuReady && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = cpuRdata;
    @(posedge clk);
    #1 cpuReq = 1'b0; cpuWrite = 1'b0;
  endtask

  task automatic snoop(input logic [AW-1:0] a);
    @(negedge clk);
    snpValid = 1'b1; snpAddr = a;
    @(posedge clk);
    #1 snpValid = 1'b0;
  endtask

  task automatic otherWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    extWr = 1'b1; extAddr = a; extData = d;
    @(posedge clk);
    #1 extWr = 1'b0;
  endtask

  task automatic t_reset_and_miss();
    logic [DW-1:0] rd; int lat, tx0;
    chk("R1 ready idle", 32'(cpuReady), 0);
    chk("R1 busReq idle", 32'(busReq), 0);
    tx0 = txCnt;
    access(1'b0, 8'h10, '0, rd, lat);
    chk("R1 cold read latency", 32'(lat), 2);
    chk("R3 miss data", 32'(rd), 32'(16'h1000 + 16'h30));
    chk("R3 one bus read", 32'(txCnt - tx0), 1);
  endtask

  task automatic t_read_hit();
    logic [DW-1:0] rd; int lat, tx0;
    tx0 = txCnt;
    access(1'b0, 8'h10, '0, rd, lat);
    chk("R2 hit latency", 32'(lat), 0);
    chk("R2 hit data", 32'(rd), 32'(16'h1030));
    chk("R2 no bus", 32'(txCnt - tx0), 0);
  endtask

  task automatic t_write_hit();
    logic [DW-1:0] rd; int lat, tx0, w0;
    tx0 = txCnt; w0 = wrCnt;
    access(1'b1, 8'h10, 16'hA5A5, rd, lat);
    chk("R5 write latency", 32'(lat), 2);
    chk("R5 one write tx", 32'(wrCnt - w0), 1);
    chk("R5 memory updated", 32'(mem[8'h10]), 32'(16'hA5A5));
    tx0 = txCnt;
    access(1'b0, 8'h10, '0, rd, lat);
    chk("R5 local copy", 32'(rd), 32'(16'hA5A5));
    chk("R5 read after write hits", 32'(txCnt - tx0), 0);
  endtask

  task automatic t_write_miss();
    logic [DW-1:0] rd; int lat, tx0;
    tx0 = txCnt;
    access(1'b1, 8'h21, 16'hB00B, rd, lat);
    chk("R6 write miss one tx", 32'(txCnt - tx0), 1);
    chk("R6 memory", 32'(mem[8'h21]), 32'(16'hB00B));
    access(1'b0, 8'h21, '0, rd, lat);
    chk("R6 line valid after write miss", 32'(lat), 0);
    chk("R6 data", 32'(rd), 32'(16'hB00B));
    // R11: 0x31 shares index 1 with 0x21
    tx0 = txCnt;
    access(1'b1, 8'h31, 16'hC0DE, rd, lat);
    chk("R7 write replace one tx", 32'(txCnt - tx0), 1);
    access(1'b0, 8'h31, '0, rd, lat);
    chk("R6 new tag hit", 32'(lat), 0);
    access(1'b0, 8'h21, '0, rd, lat);
    chk("R7 victim misses", 32'(lat), 2);
    chk("R7 victim from memory", 32'(rd), 32'(16'hB00B));
  endtask

  task automatic t_replace();
    logic [DW-1:0] rd; int lat, tx0, w0;
    tx0 = txCnt; w0 = wrCnt;
    access(1'b0, 8'h20, '0, rd, lat);
    chk("R7 conflict read miss", 32'(lat), 2);
    chk("R7 single tx", 32'(txCnt - tx0), 1);
    chk("R7 no write-back", 32'(wrCnt - w0), 0);
    chk("R11 data of 0x20", 32'(rd), 32'(16'h1060));
    access(1'b0, 8'h10, '0, rd, lat);
    chk("R7 old line gone", 32'(lat), 2);
    chk("R7 old value kept in memory", 32'(rd), 32'(16'hA5A5));
  endtask

  task automatic t_snoop_hit();
    logic [DW-1:0] rd; int lat;
    otherWrite(8'h10, 16'hD00D);
    snoop(8'h10);
    access(1'b0, 8'h10, '0, rd, lat);
    chk("R8 snooped line misses next cycle", 32'(lat), 2);
    chk("R8 fresh memory value", 32'(rd), 32'(16'hD00D));
    snoop(8'h10);
    access(1'b0, 8'h10, '0, rd, lat);
    chk("R4 matching tag on invalid line is a miss", 32'(lat), 2);
  endtask

  task automatic t_snoop_ignore();
    logic [DW-1:0] rd; int lat, tx0;
    snoop(8'h30);
    snoop(8'h13);
    tx0 = txCnt;
    access(1'b0, 8'h10, '0, rd, lat);
    chk("R9 other tag snoop no effect", 32'(lat), 0);
    chk("R9 data kept", 32'(rd), 32'(16'hD00D));
    chk("R9 no bus", 32'(txCnt - tx0), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    t_reset_and_miss();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_replace();
    t_snoop_hit();
    t_snoop_ignore();
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule